// File: doc/BRIEF.md
# EDO DRAM Pin Emulator

This block stands in for a 4-bit-wide extended-data-out DRAM on the device side of a memory controller under test. It runs on a fast sample clock and captures the active-low row strobe, column strobe, write enable and output enable, together with the multiplexed address bus and the incoming data nibble. It finds the edges of the strobes from successive samples and latches the row and column. It keeps data in a small on-chip array indexed by the low-order row and column bits. It drives read data together with an output-enable flag that a pad wrapper turns into a tri-state bus.

The emulator follows the pin-level rules that separate extended-data-out parts from older page-mode parts. Read data stays on the bus after the column strobe rises. The output enable can switch the bus off and on while both strobes are low. An output-enable high interval during column precharge, or a write-enable fall, latches the outputs off until the next column strobe fall. The block decides between early writes, late writes and read-modify-write cycles by which of the write-enable and column-strobe falls comes last. The minimum output-enable intervals are given as sample-clock cycle counts. Analog timing checks are not modelled.

Top module: `edo_pin_model`

## Requirements
- R1: A row-strobe fall latches addr[ROW_BITS-1:0] as the row. A column-strobe fall with the row strobe low latches addr[COL_BITS-1:0] as the column. If the write enable is high at that column fall, the word stored at {row, column} is loaded into dq_out, and dq_oe is 1 while oe_n is low.
- R2: If the write enable is low when the column strobe falls (having fallen earlier or in the same sampled cycle), dq_in sampled in that cycle is stored at {row, column}. dq_oe then stays 0 whatever oe_n does.
- R3: A write-enable fall while the column strobe is already low and oe_n is high stores dq_in sampled in that cycle at the latched {row, column}. dq_oe stays 0 afterwards.
- R4: A write-enable fall while the column strobe is low and oe_n is low stores nothing. dq_oe and dq_out keep showing the read data of the location.
- R5: After a read, a column-strobe rise leaves dq_oe at 1 and dq_out unchanged as long as the row strobe and oe_n stay low and the write enable stays high.
- R6: While a read is valid and both strobes are low, oe_n high gives dq_oe 0 and oe_n low gives dq_oe 1 again.
- R7: If oe_n is high when the column strobe rises and stays high for OEHC_CYC sampled cycles counting that one, dq_oe stays 0 until the next column-strobe fall, even after oe_n returns low.
- R8: If oe_n is low at the column-strobe rise and later is high for OEP_CYC consecutive sampled cycles while the column strobe is high, dq_oe stays 0 until the next column-strobe fall.
- R9: An oe_n high interval during column-strobe high that is shorter than the applicable minimum latches nothing: dq_oe returns to 1 when oe_n goes low.
- R10: A write-enable fall in any case other than R4 forces dq_oe to 0 until a column-strobe fall with the write enable high.
- R11: dq_oe goes to 0 once both strobes are sampled high. A row-strobe rise while the column strobe stays low keeps the read data driven.
- R12: A pin change reaches dq_oe and dq_out on the second rising clock edge after it is set up: one edge to sample it and one to register the result.
- R13: While rst_n is low and after its release, dq_oe and dq_out are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | DQ_W | Data from the controller |
| dq_out | output | DQ_W | Read data toward the pads |
| dq_oe | output | 1 | Pad drive enable |

## Verification
The write-enable fall and the column-strobe fall can land in the same sampled cycle. The block then sees both a possible late-write event and the start of an access. The bench provokes this by dropping both pins at the same clock edge with oe_n low. It judges the outcome two ways: dq_oe must stay 0, as for an early write, and a later read of that location must return the nibble present in that cycle. A second collision is a column-strobe fall arriving while a sticky disable from either source is latched. The bench checks that the fall clears the latch and that the new read is driven.

// File: rtl/edo_pkg.sv
package edo_pkg;

    typedef struct packed {
        logic ras;
        logic cas;
        logic we;
        logic oe;
    } strobe_t;

    typedef struct packed {
        logic ras_fall;
        logic cas_fall;
        logic cas_rise;
        logic we_fall;
    } edge_t;

    localparam strobe_t STROBE_IDLE = '{ras: 1'b1, cas: 1'b1, we: 1'b1, oe: 1'b1};

endpackage

// File: rtl/edo_pin_sampler.sv
module edo_pin_sampler
    import edo_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DQ_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  strobe_t           pins,
    input  logic [ADDR_W-1:0] addr_pin,
    input  logic [DQ_W-1:0]   dq_pin,
    output strobe_t           cur,
    output edge_t             ev,
    output logic [ADDR_W-1:0] addr_s,
    output logic [DQ_W-1:0]   dq_s
);

    typedef struct packed {
        strobe_t           cur;
        strobe_t           prev;
        logic [ADDR_W-1:0] addr;
        logic [DQ_W-1:0]   dq;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d      = smp_q;
        smp_d.prev = smp_q.cur;
        smp_d.cur  = pins;
        smp_d.addr = addr_pin;
        smp_d.dq   = dq_pin;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_q <= '{cur: STROBE_IDLE, prev: STROBE_IDLE, addr: '0, dq: '0};
        end else begin
            smp_q <= smp_d;
        end
    end

    always_comb begin
        ev.ras_fall = smp_q.prev.ras & ~smp_q.cur.ras;
        ev.cas_fall = smp_q.prev.cas & ~smp_q.cur.cas;
        ev.cas_rise = ~smp_q.prev.cas & smp_q.cur.cas;
        ev.we_fall  = smp_q.prev.we & ~smp_q.cur.we;
    end

    assign cur    = smp_q.cur;
    assign addr_s = smp_q.addr;
    assign dq_s   = smp_q.dq;

endmodule

// File: rtl/edo_cell_store.sv
module edo_cell_store #(
    parameter int ROW_BITS = 4,
    parameter int COL_BITS = 4,
    parameter int DQ_W     = 4
) (
    input  logic                         clk,
    input  logic                         wr_en,
    input  logic [ROW_BITS+COL_BITS-1:0] wr_idx,
    input  logic [DQ_W-1:0]              wr_data,
    input  logic [ROW_BITS+COL_BITS-1:0] rd_idx,
    output logic [DQ_W-1:0]              rd_data
);

    localparam int IDX_W = ROW_BITS + COL_BITS;
    localparam int DEPTH = 1 << IDX_W;

    logic [DQ_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_idx] <= wr_data;
        end
    end

    assign rd_data = cells[rd_idx];

endmodule

// File: rtl/edo_oe_ctl.sv
module edo_oe_ctl #(
    parameter int OEHC_CYC = 3,
    parameter int OEP_CYC  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic s_ras,
    input  logic s_cas,
    input  logic s_oe,
    input  logic cas_fall,
    input  logic cas_rise,
    input  logic we_fall,
    input  logic rd_start,
    input  logic late_blk,
    output logic dq_oe
);

    localparam int RUN_MAX = (OEHC_CYC > OEP_CYC) ? OEHC_CYC : OEP_CYC;
    localparam int RUN_W   = $clog2(RUN_MAX + 1) + 1;
    localparam logic [RUN_W-1:0] HC_LIM  = RUN_W'(OEHC_CYC);
    localparam logic [RUN_W-1:0] P_LIM   = RUN_W'(OEP_CYC);
    localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(RUN_MAX);

    typedef struct packed {
        logic             valid;
        logic             oe_kill;
        logic             we_kill;
        logic [RUN_W-1:0] run;
        logic             from_rise;
        logic             dq_oe;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [RUN_W-1:0] lim;

    always_comb begin
        ctl_d = ctl_q;
        lim   = HC_LIM;

        // A column fall starts a new access and clears both sticky disables.
        if (cas_fall) begin
            ctl_d.oe_kill = 1'b0;
            ctl_d.we_kill = 1'b0;
            ctl_d.valid   = rd_start;
        end

        // A write-enable fall turns the outputs off unless it is a blocked late write.
        if (we_fall && !late_blk && !cas_fall) begin
            ctl_d.we_kill = 1'b1;
        end

        // Length of the current OE-high run during column precharge.
        if (s_cas && s_oe) begin
            if (cas_rise) begin
                ctl_d.run       = RUN_W'(1);
                ctl_d.from_rise = 1'b1;
            end else if (ctl_q.run == '0) begin
                ctl_d.run       = RUN_W'(1);
                ctl_d.from_rise = 1'b0;
            end else if (ctl_q.run < RUN_TOP) begin
                ctl_d.run = ctl_q.run + RUN_W'(1);
            end
        end else begin
            ctl_d.run       = '0;
            ctl_d.from_rise = 1'b0;
        end

        lim = ctl_d.from_rise ? HC_LIM : P_LIM;
        if (s_cas && s_oe && (ctl_d.run >= lim)) begin
            ctl_d.oe_kill = 1'b1;
        end

        if (s_ras && s_cas) begin
            ctl_d.valid = 1'b0;
        end

        ctl_d.dq_oe = ctl_d.valid & ~ctl_d.oe_kill & ~ctl_d.we_kill & ~s_oe;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign dq_oe = ctl_q.dq_oe;

    // R2
    early_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_fall && !s_ras && !rd_start) |=> !dq_oe);

    // R3
    late_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_fall && !s_cas && !cas_fall && !s_ras && s_oe) |=> !dq_oe);

    // R7
    oe_sticky_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.oe_kill && !cas_fall) |=> !dq_oe);

    // R10
    we_sticky_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.we_kill && !cas_fall) |=> !dq_oe);

    // R11
    both_high_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_ras && s_cas) |=> !dq_oe);

endmodule

// File: rtl/edo_pin_model.sv
module edo_pin_model
    import edo_pkg::*;
#(
    parameter int ADDR_W   = 13,
    parameter int DQ_W     = 4,
    parameter int ROW_BITS = 4,
    parameter int COL_BITS = 4,
    parameter int OEHC_CYC = 3,
    parameter int OEP_CYC  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DQ_W-1:0]   dq_in,
    output logic [DQ_W-1:0]   dq_out,
    output logic              dq_oe
);

    localparam int IDX_W = ROW_BITS + COL_BITS;

    typedef struct packed {
        logic [ROW_BITS-1:0] row;
        logic [COL_BITS-1:0] col;
        logic [DQ_W-1:0]     dout;
    } acc_t;

    strobe_t           pins, cur;
    edge_t             ev;
    logic [ADDR_W-1:0] addr_s;
    logic [DQ_W-1:0]   dq_s;

    acc_t acc_d, acc_q;

    logic             rd_start, early_wr, late_ev, late_wr, late_blk;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic [DQ_W-1:0]  rd_data;

    assign pins = '{ras: ras_n, cas: cas_n, we: we_n, oe: oe_n};

    edo_pin_sampler #(.ADDR_W(ADDR_W), .DQ_W(DQ_W)) u_smp (
        .clk      (clk),
        .rst_n    (rst_n),
        .pins     (pins),
        .addr_pin (addr),
        .dq_pin   (dq_in),
        .cur      (cur),
        .ev       (ev),
        .addr_s   (addr_s),
        .dq_s     (dq_s)
    );

    // Access decode from sampled strobes.
    always_comb begin
        rd_start = ev.cas_fall & ~cur.ras & cur.we;
        early_wr = ev.cas_fall & ~cur.ras & ~cur.we;
        late_ev  = ev.we_fall & ~cur.cas & ~ev.cas_fall & ~cur.ras;
        late_wr  = late_ev & cur.oe;
        late_blk = late_ev & ~cur.oe;
        wr_en    = early_wr | late_wr;
        rd_idx   = {acc_q.row, addr_s[COL_BITS-1:0]};
        wr_idx   = early_wr ? rd_idx : {acc_q.row, acc_q.col};
    end

    edo_cell_store #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DQ_W(DQ_W)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (dq_s),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    always_comb begin
        acc_d = acc_q;
        if (ev.ras_fall) begin
            acc_d.row = addr_s[ROW_BITS-1:0];
        end
        if (ev.cas_fall && !cur.ras) begin
            acc_d.col = addr_s[COL_BITS-1:0];
        end
        if (rd_start) begin
            acc_d.dout = rd_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    edo_oe_ctl #(.OEHC_CYC(OEHC_CYC), .OEP_CYC(OEP_CYC)) u_oe (
        .clk      (clk),
        .rst_n    (rst_n),
        .s_ras    (cur.ras),
        .s_cas    (cur.cas),
        .s_oe     (cur.oe),
        .cas_fall (ev.cas_fall),
        .cas_rise (ev.cas_rise),
        .we_fall  (ev.we_fall),
        .rd_start (rd_start),
        .late_blk (late_blk),
        .dq_oe    (dq_oe)
    );

    assign dq_out = acc_q.dout;

    // R4
    late_blocked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (late_blk && dq_oe) |=> (dq_oe && $stable(dq_out)));

    // R5
    edo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && ev.cas_rise && !cur.ras && !cur.oe && cur.we) |=> (dq_oe && $stable(dq_out)));

endmodule

// File: tb/tb_edo_pin_model.sv
module tb_edo_pin_model;

    localparam int ADDR_W = 13;
    localparam int DQ_W   = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [DQ_W-1:0]   dq_in = '0;
    logic [DQ_W-1:0]   dq_out;
    logic              dq_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic            oe;
        logic [DQ_W-1:0] data;
        bit              use_data;
        string           tag;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;

    edo_pin_model #(.ADDR_W(ADDR_W), .DQ_W(DQ_W), .ROW_BITS(4), .COL_BITS(4),
                    .OEHC_CYC(3), .OEP_CYC(2)) dut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic drv(input logic r, input logic c, input logic w, input logic o,
                       input logic [ADDR_W-1:0] a, input logic [DQ_W-1:0] d);
        @(negedge clk);
        ras_n = r; cas_n = c; we_n = w; oe_n = o; addr = a; dq_in = d;
    endtask

    task automatic chk(input int n, input logic oe, input logic [DQ_W-1:0] data,
                       input bit use_data, input string tag);
        exp_t e;
        repeat (n) @(posedge clk);
        e.oe = oe; e.data = data; e.use_data = use_data; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: pops expectations and compares away from the clock edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (dq_oe !== e.oe) begin
                    errors++;
                    $display("FAIL %s: dq_oe actual %b expected %b", e.tag, dq_oe, e.oe);
                end else if (e.use_data && dq_out !== e.data) begin
                    errors++;
                    $display("FAIL %s: dq_out actual %h expected %h", e.tag, dq_out, e.data);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        chk(0, 1'b0, 4'h0, 1'b1, "R13 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        chk(2, 1'b0, 4'h0, 1'b1, "R13 after reset");

        // R2: WE and CAS fall in the same sampled cycle, OE low
        drv(0, 1, 1, 0, 13'h003, 4'h0);
        drv(0, 0, 0, 0, 13'h005, 4'hA);
        chk(2, 1'b0, 4'h0, 1'b0, "R2 coincident early write");
        drv(0, 1, 1, 1, 13'h005, 4'h0);
        drv(1, 1, 1, 1, 13'h000, 4'h0);

        // R2: WE falls one cycle before CAS
        drv(0, 1, 1, 1, 13'h003, 4'h0);
        drv(0, 1, 0, 1, 13'h006, 4'h5);
        drv(0, 0, 0, 0, 13'h006, 4'h5);
        chk(2, 1'b0, 4'h0, 1'b0, "R2 early write WE first");
        drv(1, 1, 1, 1, 13'h000, 4'h0);

        // R1 page reads, R5 hold, R12 latency, R6 OE toggle, R11 off
        drv(0, 1, 1, 0, 13'h003, 4'h0);
        drv(0, 0, 1, 0, 13'h005, 4'h0);
        chk(2, 1'b1, 4'hA, 1'b1, "R1 read row3 col5");
        drv(0, 1, 1, 0, 13'h005, 4'h0);
        chk(2, 1'b1, 4'hA, 1'b1, "R5 data held after CAS rise");
        drv(0, 0, 1, 0, 13'h006, 4'h0);
        chk(2, 1'b1, 4'h5, 1'b1, "R1 page read col6");
        drv(0, 0, 1, 1, 13'h006, 4'h0);
        chk(1, 1'b1, 4'h5, 1'b1, "R12 one edge after OE rise");
        chk(1, 1'b0, 4'h0, 1'b0, "R12 two edges after OE rise");
        drv(0, 0, 1, 0, 13'h006, 4'h0);
        chk(2, 1'b1, 4'h5, 1'b1, "R6 OE low again");
        drv(0, 1, 1, 0, 13'h006, 4'h0);
        drv(1, 1, 1, 0, 13'h000, 4'h0);
        chk(2, 1'b0, 4'h0, 1'b0, "R11 both strobes high");

        // R11: RAS rises while CAS low
        drv(0, 1, 1, 0, 13'h003, 4'h0);
        drv(0, 0, 1, 0, 13'h005, 4'h0);
        chk(2, 1'b1, 4'hA, 1'b1, "R1 read before RAS rise");
        drv(1, 0, 1, 0, 13'h005, 4'h0);
        chk(2, 1'b1, 4'hA, 1'b1, "R11 RAS rise with CAS low");
        drv(1, 1, 1, 0, 13'h000, 4'h0);
        chk(2, 1'b0, 4'h0, 1'b0, "R11 CAS rise last");

        // R3: read-modify-write with OE high
        drv(0, 1, 1, 1, 13'h004, 4'h0);
        drv(0, 0, 0, 1, 13'h002, 4'h3);
        drv(1, 1, 1, 1, 13'h000, 4'h0);
        drv(0, 1, 1, 0, 13'h004, 4'h0);
        drv(0, 0, 1, 0, 13'h002, 4'h0);
        chk(2, 1'b1, 4'h3, 1'b1, "R1 read before modify");
        drv(0, 0, 1, 1, 13'h002, 4'hC);
        chk(2, 1'b0, 4'h0, 1'b0, "R6 OE high in access");
        drv(0, 0, 0, 1, 13'h002, 4'hC);
        chk(2, 1'b0, 4'h0, 1'b0, "R3 late write outputs off");
        drv(1, 1, 1, 1, 13'h000, 4'h0);
        drv(0, 1, 1, 0, 13'h004, 4'h0);
        drv(0, 0, 1, 0, 13'h002, 4'h0);
        chk(2, 1'b1, 4'hC, 1'b1, "R3 late write stored");
        drv(1, 1, 1, 1, 13'h000, 4'h0);

        // R4: late WE with OE low
        drv(0, 1, 1, 1, 13'h004, 4'h0);
        drv(0, 0, 0, 1, 13'h007, 4'h9);
        drv(1, 1, 1, 1, 13'h000, 4'h0);
        drv(0, 1, 1, 0, 13'h004, 4'h0);
        drv(0, 0, 1, 0, 13'h007, 4'h0);
        chk(2, 1'b1, 4'h9, 1'b1, "R1 read before blocked write");
        drv(0, 0, 0, 0, 13'h007, 4'h6);
        chk(2, 1'b1, 4'h9, 1'b1, "R4 read data kept");
        drv(1, 1, 1, 1, 13'h000, 4'h0);
        drv(0, 1, 1, 0, 13'h004, 4'h0);
        drv(0, 0, 1, 0, 13'h007, 4'h0);
        chk(2, 1'b1, 4'h9, 1'b1, "R4 nothing stored");
        drv(1, 1, 1, 1, 13'h000, 4'h0);

        // R7: OE high at CAS rise held past the hold count
        drv(0, 1, 1, 0, 13'h003, 4'h0);
        drv(0, 0, 1, 0, 13'h005, 4'h0);
        chk(2, 1'b1, 4'hA, 1'b1, "R1 read before OE hold");
        drv(0, 0, 1, 1, 13'h005, 4'h0);
        drv(0, 1, 1, 1, 13'h005, 4'h0);
        for (int i = 0; i < 4; i++) drv(0, 1, 1, 1, 13'h005, 4'h0);
        drv(0, 1, 1, 0, 13'h005, 4'h0);
        chk(2, 1'b0, 4'h0, 1'b0, "R7 sticky off after OE hold");
        drv(0, 0, 1, 0, 13'h006, 4'h0);
        chk(2, 1'b1, 4'h5, 1'b1, "R7 cleared by CAS fall");

        // R9: OE high at CAS rise for only one cycle
        drv(0, 0, 1, 1, 13'h006, 4'h0);
        drv(0, 1, 1, 1, 13'h006, 4'h0);
        drv(0, 1, 1, 0, 13'h006, 4'h0);
        chk(2, 1'b1, 4'h5, 1'b1, "R9 short OE hold at rise");

        // R8: OE pulse during CAS high
        drv(0, 1, 1, 1, 13'h006, 4'h0);
        drv(0, 1, 1, 1, 13'h006, 4'h0);
        drv(0, 1, 1, 1, 13'h006, 4'h0);
        drv(0, 1, 1, 0, 13'h006, 4'h0);
        chk(2, 1'b0, 4'h0, 1'b0, "R8 sticky off after OE pulse");
        drv(0, 0, 1, 0, 13'h005, 4'h0);
        chk(2, 1'b1, 4'hA, 1'b1, "R8 cleared by CAS fall");
        drv(0, 1, 1, 0, 13'h005, 4'h0);
        chk(2, 1'b1, 4'hA, 1'b1, "R5 hold before short pulse");
        drv(0, 1, 1, 1, 13'h005, 4'h0);
        drv(0, 1, 1, 0, 13'h005, 4'h0);
        chk(2, 1'b1, 4'hA, 1'b1, "R9 short OE pulse");

        // R10: WE fall during CAS high
        drv(0, 1, 0, 0, 13'h005, 4'h0);
        chk(2, 1'b0, 4'h0, 1'b0, "R10 WE fall turns off");
        drv(0, 1, 1, 0, 13'h005, 4'h0);
        chk(2, 1'b0, 4'h0, 1'b0, "R10 stays off after WE rise");
        drv(0, 0, 1, 0, 13'h006, 4'h0);
        chk(2, 1'b1, 4'h5, 1'b1, "R10 read CAS fall re-enables");
        drv(1, 1, 1, 1, 13'h000, 4'h0);

        // R1: only the low address bits index the array
        drv(0, 1, 1, 1, 13'h013, 4'h0);
        drv(0, 0, 0, 1, 13'h021, 4'hE);
        drv(1, 1, 1, 1, 13'h000, 4'h0);
        drv(0, 1, 1, 0, 13'h003, 4'h0);
        drv(0, 0, 1, 0, 13'h001, 4'h0);
        chk(2, 1'b1, 4'hE, 1'b1, "R1 reduced address alias");
        drv(1, 1, 1, 1, 13'h000, 4'h0);

        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule